// File: doc/BRIEF.md
# Host Word-Stream to DMA Request FIFO

This block sits between a 16-bit host bus and one channel of a CPU-side DMA controller. The host sets up a transfer by writing a length register and setting an enable bit in a control register. It then writes 16-bit words one at a time into a data register. The words go into a small FIFO. The DMA channel is loaded with its own transfer count. It drains the FIFO word by word through a pop port whenever the block raises its request line.

Requests are released in groups of four. The request line rises only once a full group of four written words is waiting. It also needs the channel to be in demand mode with the master DMA enable set and a nonzero count remaining. Each delivered word lowers the channel count. When the count reaches zero, the transfer is complete:
- the FIFO is emptied;
- the enable bit drops;
- the full flag clears;
- a sticky done bit is raised toward the channel.

Top module: `host_dma_fifo_bridge`

## Requirements
- R1: After reset, the control register reads 0x0000, the length register reads 0x0000, `dreq` is low, `chan_count` is 0 and `chan_done` is low.
- R2: Host register map, by byte offset on `host_addr`. 0x10 is the 16-bit length register, which can be written and read back. 0x06 is the control register:
  - bit 2 is the enable bit, which can be written and read;
  - bit 3 is the sticky mismatch flag, read-only;
  - bit 7 is the full flag, read-only;
  - all other bits read 0.
  The data register at 0x12 and any other offset read 0x0000.
- R3: A write to offset 0x12 while the enable bit is 0 stores nothing. `drop_flag` is high for exactly the cycle after that write.
- R4: The FIFO holds 8 words. The full bit (bit 7) reads 1 exactly when 8 words are held. A data write while full is discarded and pulses `drop_flag`, even if a word is popped in the same cycle.
- R5: `dreq` is asserted only while at least one word from a completed group of four is unread. Each group is counted from the start of the transfer. Words of an incomplete group (1 to 3 words past the last boundary) are never requested until their fourth word is written.
- R6: `dreq` additionally requires `chan_mode` equal to 2'b01, `dma_master_en` high and `chan_count` nonzero.
- R7: When `dma_pop` is high while `dreq` is high, `pop_data` shows the oldest unread word in write order, that word is consumed and `chan_count` drops by one. `dma_pop` while `dreq` is low, or in a cycle with `chan_arm` high, has no effect.
- R8: `chan_arm` loads `chan_count` with the low 24 bits of `chan_count_in` and clears `chan_done`.
- R9: A pop that brings `chan_count` from 1 to 0 completes the transfer. On the next cycle `chan_done` is 1, the enable bit and full bit are 0, and every unread word is discarded. A data write in the same cycle as that pop is also lost.
- R10: On `chan_arm`, if the loaded 24-bit count differs from the zero-extended length register, the mismatch bit (bit 3) becomes 1. It then stays 1 until reset.
- R11: A pop that drains a group while `chan_count` stays nonzero leaves the enable bit set. Later groups are requested without further setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Host byte offset, decodes writes and selects read data |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the selected offset (combinational) |
| drop_flag | output | 1 | Pulses the cycle after a discarded data write |
| chan_arm | input | 1 | Loads the channel transfer count |
| chan_count_in | input | 32 | Count value presented at arm |
| chan_mode | input | 2 | Channel request mode; 2'b01 selects demand requests |
| dma_master_en | input | 1 | Master DMA enable |
| dreq | output | 1 | DMA request |
| dma_pop | input | 1 | Consume one word |
| pop_data | output | 16 | Oldest unread word |
| chan_count | output | 24 | Remaining channel transfer count |
| chan_done | output | 1 | Transfer ended normally (sticky until next arm) |

## Verification
Two functions can fall in the same cycle.

The first pair is a host push and a DMA pop. A push with a pop on a non-final word must move both the occupancy and the released-word count correctly. A push with a pop while the FIFO is full must still refuse the push.

The second pair is the pop that completes the transfer and a host data write. The completion must win, so the written word disappears.

Both cases are forced by directed sequences and also arise from random stimulus, where the bench drives pops and writes independently every cycle. Each step is judged against a bench model that applies the stated precedence.

// File: rtl/hdf_pkg.sv
package hdf_pkg;
  localparam logic [5:0] OFS_CTRL = 6'h06;
  localparam logic [5:0] OFS_LEN  = 6'h10;
  localparam logic [5:0] OFS_DATA = 6'h12;
  localparam int BIT_EN   = 2;
  localparam int BIT_MISM = 3;
  localparam int BIT_FULL = 7;
  localparam logic [1:0] MODE_DEMAND = 2'b01;

  // control register image seen by the host
  function automatic logic [15:0] ctrl_word(input logic en, input logic mism, input logic full);
    logic [15:0] w;
    w = '0;
    w[BIT_EN]   = en;
    w[BIT_MISM] = mism;
    w[BIT_FULL] = full;
    return w;
  endfunction
endpackage

// File: rtl/hdf_store.sv
module hdf_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [PW:0]   occ,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wr_ptr, rd_ptr;

  assign occ   = wr_ptr - rd_ptr;
  assign full  = (occ == (PW+1)'(DEPTH));
  assign rdata = mem[rd_ptr[PW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[PW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/hdf_release.sv
module hdf_release #(
  parameter int DEPTH = 8,
  parameter int GROUP = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int GW   = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        push,
  input  logic        pop,
  output logic [PW:0] avail,
  output logic        group_done
);
  logic [GW-1:0] fill;

  function automatic logic [PW:0] avail_next(input logic [PW:0] cur, input logic grp, input logic take);
    logic [PW:0] v;
    v = cur;
    if (grp)  v = v + (PW+1)'(GROUP);
    if (take) v = v - 1'b1;
    return v;
  endfunction

  assign group_done = push && (fill == GW'(GROUP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fill  <= '0;
      avail <= '0;
    end else begin
      avail <= avail_next(avail, group_done, pop);
      if (group_done)  fill <= '0;
      else if (push)   fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/hdf_chan.sv
module hdf_chan #(
  parameter int CNT_W = 24,
  parameter int CIN_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CIN_W-1:0] count_in,
  input  logic [LEN_W-1:0] len,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             last,
  output logic             mism
);
  logic [CNT_W-1:0] load_val;

  assign load_val = count_in[CNT_W-1:0];
  assign last     = pop && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
      mism  <= 1'b0;
    end else if (arm) begin
      count <= load_val;
      done  <= 1'b0;
      if (load_val != CNT_W'(len)) mism <= 1'b1;
    end else if (pop) begin
      count <= count - 1'b1;
      if (last) done <= 1'b1;
    end
  end
endmodule

// File: rtl/host_dma_fifo_bridge.sv
module host_dma_fifo_bridge #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int GROUP  = 4,
  parameter int CNT_W  = 24,
  parameter int CIN_W  = 32,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [5:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              drop_flag,
  input  logic              chan_arm,
  input  logic [CIN_W-1:0]  chan_count_in,
  input  logic [1:0]        chan_mode,
  input  logic              dma_master_en,
  output logic              dreq,
  input  logic              dma_pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  chan_count,
  output logic              chan_done
);
  import hdf_pkg::*;

  logic              xfer_en;
  logic [DATA_W-1:0] len_reg;
  logic              data_wr, push, pop_ok, complete, full, mism, group_done;
  logic [PW:0]       occ, avail;

  assign data_wr = host_wr && (host_addr == OFS_DATA);
  assign pop_ok  = dma_pop && dreq && !chan_arm;
  assign push    = data_wr && xfer_en && !full && !complete;
  assign dreq    = (avail != '0) && (chan_mode == MODE_DEMAND) && dma_master_en
                   && (chan_count != '0);

  hdf_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(complete), .push(push), .pop(pop_ok),
    .wdata(host_wdata), .rdata(pop_data), .occ(occ), .full(full)
  );

  hdf_release #(.DEPTH(DEPTH), .GROUP(GROUP)) u_release (
    .clk(clk), .rst_n(rst_n), .clr(complete), .push(push), .pop(pop_ok),
    .avail(avail), .group_done(group_done)
  );

  hdf_chan #(.CNT_W(CNT_W), .CIN_W(CIN_W), .LEN_W(DATA_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .arm(chan_arm), .count_in(chan_count_in),
    .len(len_reg), .pop(pop_ok), .count(chan_count), .done(chan_done),
    .last(complete), .mism(mism)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_en   <= 1'b0;
      len_reg   <= '0;
      drop_flag <= 1'b0;
    end else begin
      drop_flag <= data_wr && (!xfer_en || full);
      if (complete)
        xfer_en <= 1'b0;
      else if (host_wr && host_addr == OFS_CTRL)
        xfer_en <= host_wdata[BIT_EN];
      if (host_wr && host_addr == OFS_LEN)
        len_reg <= host_wdata;
    end
  end

  always_comb begin
    case (host_addr)
      OFS_CTRL: host_rdata = DATA_W'(ctrl_word(xfer_en, mism, full));
      OFS_LEN:  host_rdata = len_reg;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hdf_checker.sv
module hdf_checker #(
  parameter int PW    = 3,
  parameter int CNT_W = 24,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             full,
  input logic [PW:0]      occ,
  input logic [PW:0]      avail,
  input logic [CNT_W-1:0] count,
  input logic             done,
  input logic             pop_ok,
  input logic             push,
  input logic             complete,
  input logic             data_wr
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (PW+1)'(DEPTH)); // R4
  AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (full && data_wr) |=> occ <= $past(occ)); // R4
  AST_AVAIL_WITHIN_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= occ); // R5
  AST_RELEASE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (avail > $past(avail)) |-> $past(push)); // R5
  AST_DISABLED_WRITE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !en && !pop_ok) |=> occ == $past(occ)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> count == $past(count) - 1'b1); // R7
  AST_COMPLETE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (done && !en && !full && occ == '0)); // R9
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> count == '0); // R9
endmodule

bind host_dma_fifo_bridge hdf_checker #(.PW(PW), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(xfer_en), .full(full), .occ(occ), .avail(avail),
  .count(chan_count), .done(chan_done), .pop_ok(pop_ok), .push(push),
  .complete(complete), .data_wr(data_wr)
);

// File: tb/host_dma_fifo_bridge_test.sv
`timescale 1ns/1ps
module host_dma_fifo_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        drop_flag;
  logic        chan_arm = 1'b0;
  logic [31:0] chan_count_in = '0;
  logic [1:0]  chan_mode = 2'b01;
  logic        dma_master_en = 1'b1;
  logic        dreq;
  logic        dma_pop = 1'b0;
  logic [15:0] pop_data;
  logic [23:0] chan_count;
  logic        chan_done;

  always #2.5 clk = ~clk;

  host_dma_fifo_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .drop_flag(drop_flag),
    .chan_arm(chan_arm), .chan_count_in(chan_count_in), .chan_mode(chan_mode),
    .dma_master_en(dma_master_en), .dreq(dreq), .dma_pop(dma_pop),
    .pop_data(pop_data), .chan_count(chan_count), .chan_done(chan_done)
  );

  int nchk = 0, nfail = 0;
  string cur_tag = "R1";
  bit [1:0] b_mode = 2'b01;
  bit b_men = 1'b1;

  // bench model
  logic [15:0] q[$];
  int  m_avail = 0, m_grp = 0;
  bit  m_en = 0, m_mism = 0, m_done = 0, m_drop = 0;
  logic [15:0] m_len = '0;
  logic [23:0] m_count = '0;

  function automatic bit e_dreq();
    return (m_avail > 0) && (b_mode == 2'b01) && b_men && (m_count != 0);
  endfunction

  function automatic logic [15:0] e_ctrl();
    logic [15:0] w = '0;
    w[7] = (q.size() == 8);
    w[3] = m_mism;
    w[2] = m_en;
    return w;
  endfunction

  function automatic void model(bit wr, logic [5:0] a, logic [15:0] d, bit pop, bit arm, logic [31:0] cin);
    bit popv, compl, isfull, dw, pu;
    popv   = pop && e_dreq() && !arm;
    compl  = popv && (m_count == 24'd1);
    isfull = (q.size() == 8);
    dw     = wr && (a == 6'h12);
    pu     = dw && m_en && !isfull && !compl;
    m_drop = dw && (!m_en || isfull);
    if (arm) begin
      m_count = cin[23:0];
      m_done  = 0;
      if (cin[23:0] != {8'h00, m_len}) m_mism = 1;
    end
    if (compl) begin
      q.delete();
      m_avail = 0; m_grp = 0; m_count = 0; m_done = 1; m_en = 0;
    end else begin
      if (popv) begin
        void'(q.pop_front());
        m_avail--; m_count--;
      end
      if (pu) begin
        q.push_back(d);
        if (m_grp == 3) begin m_avail += 4; m_grp = 0; end
        else m_grp++;
      end
      if (wr && a == 6'h06) m_en = d[2];
    end
    if (wr && a == 6'h10) m_len = d;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [5:0] a, input logic [15:0] d,
                      input bit pop, input bit arm, input logic [31:0] cin);
    @(negedge clk);
    host_wr = 0; dma_pop = 0; chan_arm = 0; host_addr = 6'h06;
    chan_mode = b_mode; dma_master_en = b_men;
    #1;
    chk(host_rdata, e_ctrl(), "control register");
    chk(dreq, e_dreq(), "dreq");
    chk(chan_count, m_count, "channel count");
    chk(chan_done, m_done, "done");
    chk(drop_flag, m_drop, "drop flag");
    host_wr = wr; host_addr = a; host_wdata = d; dma_pop = pop;
    chan_arm = arm; chan_count_in = cin;
    #1;
    if (pop && e_dreq() && !arm) chk(pop_data, q[0], "pop data order");
    @(posedge clk);
    model(wr, a, d, pop, arm, cin);
  endtask

  task automatic lit(input logic [5:0] a, input logic [15:0] exp, input string what);
    @(negedge clk);
    host_wr = 0; dma_pop = 0; chan_arm = 0; host_addr = a;
    chan_mode = b_mode; dma_master_en = b_men;
    #1;
    chk(host_rdata, exp, what);
    @(posedge clk);
    model(0, a, 0, 0, 0, 0);
  endtask

  task automatic idle(); step(0, 6'h06, 0, 0, 0, 0); endtask
  task automatic wdat(input logic [15:0] d); step(1, 6'h12, d, 0, 0, 0); endtask
  task automatic pop1(); step(0, 6'h06, 0, 1, 0, 0); endtask
  task automatic arm(input logic [31:0] c); step(0, 6'h06, 0, 0, 1, c); endtask
  task automatic enable(); step(1, 6'h06, 16'h0004, 0, 0, 0); endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL %s watchdog expired: actual=hung expected=finished", cur_tag);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    cur_tag = "R1";
    lit(6'h06, 16'h0000, "reset control");
    lit(6'h10, 16'h0000, "reset length");
    #1 chk(dreq, 1'b0, "reset dreq");
    chk(chan_count, 24'd0, "reset count");
    chk(chan_done, 1'b0, "reset done");

    cur_tag = "R2";
    step(1, 6'h10, 16'h0005, 0, 0, 0);
    lit(6'h10, 16'h0005, "length readback");
    lit(6'h12, 16'h0000, "data register reads zero");
    lit(6'h08, 16'h0000, "unmapped offset");

    cur_tag = "R3";
    for (int i = 0; i < 4; i++) wdat(16'hA000 + 16'(i));
    idle();
    #1 chk(dreq, 1'b0, "no request from disabled writes");

    cur_tag = "R10";
    arm(32'd5);
    lit(6'h06, 16'h0000, "matching count no mismatch");
    cur_tag = "R8";
    arm(32'hFF00_0005);
    idle();
    chk(chan_count, 24'd5, "count masked to 24 bits");
    lit(6'h06, 16'h0000, "masked count matches length");
    cur_tag = "R10";
    arm(32'd7);
    arm(32'd5);
    lit(6'h06, 16'h0008, "mismatch sticky");

    cur_tag = "R5";
    enable();
    wdat(16'h1111); wdat(16'h2222); wdat(16'h3333);
    idle();
    #1 chk(dreq, 1'b0, "three words no request");
    wdat(16'h4444);
    idle();
    #1 chk(dreq, 1'b1, "fourth word raises request");
    wdat(16'h5555); wdat(16'h6666);
    for (int i = 0; i < 4; i++) pop1();
    idle();
    #1 chk(dreq, 1'b0, "partial group not requested");
    cur_tag = "R11";
    lit(6'h06, 16'h000C, "enable kept mid transfer");
    wdat(16'h7777); wdat(16'h8888);
    idle();
    #1 chk(dreq, 1'b1, "next group requested");
    cur_tag = "R9";
    pop1();
    idle();
    chk(chan_done, 1'b1, "done after last word");
    lit(6'h06, 16'h0008, "enable and full cleared");

    cur_tag = "R6";
    arm(32'd10); enable();
    for (int i = 0; i < 4; i++) wdat(16'hB000 + 16'(i));
    b_mode = 2'b10; idle();
    #1 chk(dreq, 1'b0, "mode not demand");
    b_mode = 2'b01; b_men = 1'b0; idle();
    #1 chk(dreq, 1'b0, "master disabled");
    b_men = 1'b1; idle();
    #1 chk(dreq, 1'b1, "all conditions met");
    arm(32'd0); idle();
    #1 chk(dreq, 1'b0, "zero count");

    cur_tag = "R4";
    for (int i = 0; i < 4; i++) wdat(16'hC000 + 16'(i));
    lit(6'h06, 16'h008C, "full bit at eight words");
    wdat(16'hDEAD);
    idle();
    arm(32'd50);
    step(1, 6'h12, 16'hBEEF, 1, 0, 0);
    idle();
    lit(6'h06, 16'h000C, "full push refused during pop");
    for (int i = 0; i < 7; i++) pop1();

    cur_tag = "R9";
    arm(32'd1); enable();
    for (int i = 0; i < 4; i++) wdat(16'hE000 + 16'(i));
    step(1, 6'h12, 16'hF00D, 1, 0, 0);
    idle();
    lit(6'h06, 16'h0008, "same-cycle write lost on completion");

    cur_tag = "R7";
    arm(32'd40); enable();
    for (int n = 0; n < 4000; n++) begin
      bit wr, pop, am;
      logic [5:0] a;
      logic [15:0] d;
      logic [31:0] cin;
      int r;
      b_mode = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b01;
      b_men  = ($urandom_range(0, 9) != 0);
      wr  = ($urandom_range(0, 9) < 6);
      r   = $urandom_range(0, 9);
      a   = (r < 8) ? 6'h12 : (r == 8) ? 6'h06 : 6'h10;
      d   = 16'($urandom);
      if (a == 6'h06) d[2] = ($urandom_range(0, 4) != 0);
      pop = $urandom_range(0, 1);
      am  = ($urandom_range(0, 39) == 0);
      cin = $urandom_range(0, 1) ? $urandom : 32'($urandom_range(1, 24));
      step(wr, a, d, pop, am, cin);
    end
    idle();

    summary();
    $finish;
  end
endmodule